// File: doc/BRIEF.md
# Interleaved Pipelined-Adder Accumulator

This block sums a stream of integer values with a single adder that takes several cycles per addition. The adder's output is routed back as one of its operands. Because the adder has `ADD_LAT` stages, `ADD_LAT` separate partial sums travel round the loop at the same time. Each arriving element joins whichever partial sum is leaving the pipeline in that cycle. The input is never held off by the loop-carried dependency while a stream is being accumulated.

After the element flagged as last has been taken, the block stops accepting input. It then merges the partial sums that are still live, using the same adder. Each partial sum that comes out of the pipeline either waits in a holding register or is added to the value already waiting there. A counter keeps track of how many live values remain. When exactly one value is left and it comes out of the pipeline, that value is presented with a one-cycle done strobe. The block is then ready for the next stream. Arithmetic is two's complement and wraps modulo 2^`DATA_W`.

Top module: `ilv_accum`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: `out_sum` at the done strobe equals the sum, modulo 2^`DATA_W`, of every element accepted from the start of the stream through the element with `in_last` = 1. An element is accepted when `in_valid` and `in_ready` are both 1 at a rising clock edge.
- R3: `in_data` has no effect on the result in cycles where `in_valid` is 0. Any number of such gap cycles may appear between elements.
- R4: A stream shorter than `ADD_LAT` elements, down to a single element, gives the correct total. Slots that received no element count as zero.
- R5: Streams of `ADD_LAT`-1, `ADD_LAT`, `ADD_LAT`+1 and 10×`ADD_LAT` elements give the correct total.
- R6: In the cycle after the last element is accepted, `in_ready` goes to 0. It stays at 0 until the done strobe, and elements offered in that window are not accepted and do not affect any sum.
- R7: `out_valid` is high for exactly one cycle per stream. `in_ready` is 1 again in that same cycle.
- R8: `out_valid` stays 0 while a stream is still being accepted.
- R9: Each stream's total is independent of earlier streams, including a stream that starts in the cycle right after a done strobe.
- R10: The value sums wrap: elements near 2^`DATA_W` produce the truncated `DATA_W`-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element present on `in_data` |
| in_data | input | DATA_W | Element to accumulate |
| in_last | input | 1 | Marks the final element of a stream |
| in_ready | output | 1 | Block can accept an element this cycle |
| out_valid | output | 1 | One-cycle strobe: total is on `out_sum` |
| out_sum | output | DATA_W | Accumulated total, registered |

## Verification
Suppose a partial sum is dropped, added twice or left in the pipeline from the previous stream. The error appears as a wrong `out_sum` at that stream's done strobe, a few tens of cycles after the last element. A live-value count that is off by one shows up in the same window: either the strobe fires while a partial is still circulating, giving a wrong total, or the strobe never fires and `in_ready` stays low. A mistake in the input gating shows up as `in_ready` staying high after the last element, or as an element offered during the merge finding its way into the next total.

// File: rtl/ilv_accum_pkg.sv
package ilv_accum_pkg;

  typedef enum logic {
    ST_FILL  = 1'b0,  // taking stream elements
    ST_MERGE = 1'b1   // folding residual partial sums
  } acc_phase_e;

endpackage

// File: rtl/acc_pipe_add.sv
// Multi-cycle two's-complement adder: the sum is formed in the first stage
// and walks through LAT-1 delay registers. A valid bit travels with each
// slot. Only the valid bits are reset; data registers need no reset, so a
// tool may map the delay chain onto shift-register primitives.
module acc_pipe_add #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         add_v,
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  output logic         res_v,
  output logic [W-1:0] res_d
);

  logic [W-1:0] stg_d [LAT];
  logic [LAT-1:0] stg_v;

  always_ff @(posedge clk) begin
    stg_d[0] <= add_a + add_b;
    for (int s = 1; s < LAT; s++) begin
      stg_d[s] <= stg_d[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= '0;
    end else begin
      stg_v[0] <= add_v;
      for (int s = 1; s < LAT; s++) begin
        stg_v[s] <= stg_v[s-1];
      end
    end
  end

  assign res_v = stg_v[LAT-1];
  assign res_d = stg_d[LAT-1];

endmodule

// File: rtl/acc_ctrl.sv
// Operand steering, live-value bookkeeping and the merge sequence.
module acc_ctrl
  import ilv_accum_pkg::*;
#(
  parameter int W   = 32,
  parameter int LAT = 4,
  parameter int CW  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         in_ready,
  input  logic         res_v,
  input  logic [W-1:0] res_d,
  output logic         add_v,
  output logic [W-1:0] add_a,
  output logic [W-1:0] add_b,
  output logic         out_valid,
  output logic [W-1:0] out_sum
);

  acc_phase_e   phase_q;
  logic [CW-1:0] live_q;    // valid slots in the loop while filling
  logic [CW-1:0] left_q;    // values still to fold while merging
  logic [W-1:0]  park_q;    // partial waiting for a partner
  logic          park_v_q;
  logic          take;
  logic [CW-1:0] live_nxt;

  assign in_ready = (phase_q == ST_FILL);
  assign take     = in_valid && in_ready;
  assign live_nxt = live_q + CW'(1) - CW'(res_v);

  always_comb begin
    add_v = 1'b0;
    add_a = '0;
    add_b = '0;
    if (phase_q == ST_FILL) begin
      // every fill cycle launches a slot; empty slots feed back as zero
      add_v = 1'b1;
      add_a = take  ? in_data : '0;
      add_b = res_v ? res_d   : '0;
    end else if (res_v && park_v_q) begin
      add_v = 1'b1;
      add_a = park_q;
      add_b = res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= ST_FILL;
      live_q    <= '0;
      left_q    <= '0;
      park_q    <= '0;
      park_v_q  <= 1'b0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= 1'b0;
      case (phase_q)
        ST_FILL: begin
          live_q <= live_nxt;
          if (take && in_last) begin
            phase_q <= ST_MERGE;
            left_q  <= live_nxt;
          end
        end
        default: begin
          if (res_v) begin
            if (park_v_q) begin
              park_v_q <= 1'b0;
              left_q   <= left_q - CW'(1);
            end else if (left_q == CW'(1)) begin
              out_sum   <= res_d;
              out_valid <= 1'b1;
              phase_q   <= ST_FILL;
              live_q    <= '0;
            end else begin
              park_q   <= res_d;
              park_v_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ilv_accum.sv
module ilv_accum #(
  parameter int DATA_W  = 32,
  parameter int ADD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sum
);

  localparam int CNT_W = $clog2(ADD_LAT + 1);

  logic              add_v;
  logic [DATA_W-1:0] add_a;
  logic [DATA_W-1:0] add_b;
  logic              res_v;
  logic [DATA_W-1:0] res_d;

  acc_pipe_add #(
    .W   (DATA_W),
    .LAT (ADD_LAT)
  ) u_add (
    .clk   (clk),
    .rst   (rst),
    .add_v (add_v),
    .add_a (add_a),
    .add_b (add_b),
    .res_v (res_v),
    .res_d (res_d)
  );

  acc_ctrl #(
    .W   (DATA_W),
    .LAT (ADD_LAT),
    .CW  (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .res_v     (res_v),
    .res_d     (res_d),
    .add_v     (add_v),
    .add_a     (add_a),
    .add_b     (add_b),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

endmodule

// File: rtl/ilv_accum_chk.sv
module ilv_accum_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_last,
  input logic in_ready,
  input logic out_valid
);

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !(in_valid && in_last)) |=> in_ready);

  // R6
  ready_return_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> out_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  // R8
  done_after_merge_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(!in_ready));

endmodule

bind ilv_accum ilv_accum_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/sim_ilv_accum.sv
`timescale 1ns/1ps
module sim_ilv_accum;

  localparam int W = 32;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_last = 1'b0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_sum;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ilv_accum #(.DATA_W(W), .ADD_LAT(N)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one stream, then watches the merge and the done strobe.
  task automatic run_stream(input int len, input int gap_max, input bit wrap, input string req);
    logic [W-1:0] exp_sum = '0;
    bit early_done = 1'b0;
    bit ready_bad  = 1'b0;
    int waits = 0;
    for (int k = 0; k < len; k++) begin
      int g = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      for (int j = 0; j < g; j++) begin
        @(negedge clk);
        early_done |= out_valid;
        in_valid = 1'b0;
        in_last  = 1'b1;
        in_data  = $urandom;       // R3: junk while invalid
      end
      @(negedge clk);
      early_done |= out_valid;
      in_valid = 1'b1;
      in_data  = wrap ? (32'hFFFF_FFF0 + 32'(k)) : $urandom;
      in_last  = (k == len - 1);
      exp_sum  = exp_sum + in_data;
    end
    @(negedge clk);
    // R8: no strobe while the stream was being taken
    check(!early_done, "R8 no done during fill", early_done, 0);
    // R6: ready drops right after the last element
    check(!in_ready, "R6 ready low after last", in_ready, 0);
    in_valid = 1'b1;
    in_last  = 1'b1;
    in_data  = 32'h5A5A_0001;      // R6: offered during merge, must be ignored
    while (!out_valid && waits < 2000) begin
      ready_bad |= in_ready;
      @(negedge clk);
      waits++;
    end
    check(!ready_bad, "R6 ready stays low during merge", ready_bad, 0);
    check(out_valid, {req, " done strobe seen"}, out_valid, 1);
    check(out_sum == exp_sum, {req, " total"}, out_sum, exp_sum);
    check(in_ready, "R7 ready back with strobe", in_ready, 1);
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    check(!out_valid, "R7 strobe lasts one cycle", out_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R1 in reset", {in_ready, out_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready && !out_valid, "R1 after reset", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic t_single();    run_stream(1, 0, 1'b0, "R4 length 1");       endtask
  task automatic t_short();     run_stream(N - 1, 3, 1'b0, "R4 length N-1");  endtask
  task automatic t_exact();     run_stream(N, 3, 1'b0, "R5 length N");       endtask
  task automatic t_plus_one();  run_stream(N + 1, 3, 1'b0, "R5 length N+1"); endtask
  task automatic t_long();      run_stream(10 * N, 4, 1'b0, "R5 length 10N"); endtask
  task automatic t_gaps();      run_stream(2 * N + 3, 6, 1'b0, "R3 gapped stream"); endtask
  task automatic t_wrap();      run_stream(3 * N, 0, 1'b1, "R10 wrapping total"); endtask
  task automatic t_back2back();
    run_stream(N + 2, 0, 1'b0, "R9 first of pair");
    run_stream(N - 1, 0, 1'b0, "R9 second of pair");
    run_stream(1, 0, 1'b0, "R2 single after pair");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_short();
    t_exact();
    t_plus_one();
    t_long();
    t_gaps();
    t_wrap();
    t_back2back();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule